// File: doc/BRIEF.md
# Operation-Driven Bus and Address Combiner

This block is the purely combinational bus front end of a small 16-bit CPU whose instructions carry no addressing-mode fields. Every register reports, for the current operation, whether it drives its value as data and whether it drives it as an address. From these enables alone the block builds the whole bus cycle. The address is the wrapped sum of every register that projects an address, so indirect, base-plus-index and stacked modes come out of the same adder. The internal data bus is a wired OR of every register that projects data, with memory input folded in during reads. The direction of the cycle follows from whether any register projects data.

Two fixed instruction words send the flag register to memory. When either is present, the outgoing data bus carries the flags in place of the internal bus. The control unit can take over the address bus to show its microcode step, and it can release every external driver during a hold acknowledge. Tri-state control leaves the block as explicit output enables, which the pads use.

Top module: `opbus_combiner`

## Requirements
- R1: `o_int_bus` is the bitwise OR of each register value whose data-enable is high, with `i_data_en` bits P=0, A=1, X=2, Y=3, S=4; with no enable and no memory selection it is 0.
- R2: `i_mem_din` is ORed onto `o_int_bus` when `i_int_ack` is 1, or when `o_vma` is 1 and `o_rnw` is 1, and at no other time.
- R3: With `i_bus_ctrl` high, `o_addr` is the sum modulo 65536 of the P, X, Y and S values whose address-enable is high, with `i_addr_en` bits P=0, X=1, Y=2, S=3; the A register and the flags never enter the sum.
- R4: `o_vma` is 1 exactly when `i_bus_ctrl` is 1, `i_int_ack` is 0 and at least one address-enable is high.
- R5: `o_rnw` is 0 when `o_vma` is 1 and any data-enable is high, or when the instruction is a flag-store word; otherwise it is 1.
- R6: The flag-store words are 16'h0006 (flags to top of stack) and 16'h0003 (flags pushed); for either, `o_dout` carries `i_flags`, and for any other word it carries `o_int_bus`.
- R7: `o_pnd` equals the program counter's address-enable, `i_addr_en[0]`.
- R8: When `i_bus_ctrl` is 0, `o_addr` is `i_upc` zero-extended and `o_vma` is 0.
- R9: When `i_hold_ack` is 1, `o_addr_oe`, `o_ctl_oe` and `o_dout_oe` are all 0; otherwise `o_addr_oe` and `o_ctl_oe` are 1 and `o_dout_oe` equals the inverse of `o_rnw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_reg_p | input | 16 | Program counter value |
| i_reg_a | input | 16 | Accumulator value |
| i_reg_x | input | 16 | First index register value |
| i_reg_y | input | 16 | Second index register value |
| i_reg_s | input | 16 | Stack pointer value |
| i_data_en | input | 5 | Data-enable per register (P,A,X,Y,S from bit 0) |
| i_addr_en | input | 4 | Address-enable per register (P,X,Y,S from bit 0) |
| i_mem_din | input | 16 | Data read from memory |
| i_flags | input | 16 | Flag register value |
| i_instr | input | 16 | Current instruction word |
| i_upc | input | 8 | Microcode step index |
| i_bus_ctrl | input | 1 | 1 = normal addressing, 0 = step index on address bus |
| i_int_ack | input | 1 | Interrupt vector read cycle |
| i_hold_ack | input | 1 | Bus released to another master |
| o_int_bus | output | 16 | Internal data bus |
| o_addr | output | 16 | Address bus value |
| o_addr_oe | output | 1 | Address bus driver enable |
| o_vma | output | 1 | Valid memory address |
| o_rnw | output | 1 | 1 = read, 0 = write |
| o_pnd | output | 1 | 1 = program-space access |
| o_ctl_oe | output | 1 | Enable for the VMA, RnW and PnD drivers |
| o_dout | output | 16 | Outgoing data bus value |
| o_dout_oe | output | 1 | Outgoing data bus driver enable |

## Verification
The assertions take the inputs as settled, stable levels: enables and register values are produced by upstream registers, and the checks read them as a coherent set rather than mid-transition. They also take the instruction word to be the one whose enables are presented, so the flag-store detection and the enables agree in time. The bench honours both by changing all inputs together and reading outputs only after a settling delay, while sweeping every combination of data-enables, address-enables, interrupt acknowledge, bus control, hold and four instruction words, with register values drawn from a hash that includes all-ones patterns to force adder wrap.

// File: rtl/opbus_pkg.sv
package opbus_pkg;

  localparam int INSTR_W   = 16;
  localparam int S_FIELD_W = 3;

  // stack-register operation codes held in the low field of the instruction
  localparam logic [S_FIELD_W-1:0] S_OP_PUSH = 3'd3;
  localparam logic [S_FIELD_W-1:0] S_OP_TOS  = 3'd6;

  // the two flag-store words: every other field is its no-op code (0)
  localparam logic [INSTR_W-1:0] WORD_FLAG_PUSH = INSTR_W'(S_OP_PUSH);
  localparam logic [INSTR_W-1:0] WORD_FLAG_TOS  = INSTR_W'(S_OP_TOS);

  typedef enum int {
    DSRC_P = 0,
    DSRC_A = 1,
    DSRC_X = 2,
    DSRC_Y = 3,
    DSRC_S = 4
  } dsrc_e;

  typedef enum int {
    ASRC_P = 0,
    ASRC_X = 1,
    ASRC_Y = 2,
    ASRC_S = 3
  } asrc_e;

  localparam int N_DSRC = 5;
  localparam int N_ASRC = 4;

  function automatic logic is_flag_store(input logic [INSTR_W-1:0] w);
    return (w == WORD_FLAG_TOS) || (w == WORD_FLAG_PUSH);
  endfunction

endpackage

// File: rtl/opbus_data_merge.sv
module opbus_data_merge #(
  parameter int W = 16,
  parameter int N = 5
) (
  input  logic [N*W-1:0] i_src,
  input  logic [N-1:0]   i_en,
  input  logic [W-1:0]   i_mem,
  input  logic           i_mem_sel,
  output logic [W-1:0]   o_bus
);

  logic [W-1:0] gated [N];
  logic [W-1:0] mem_gated;
  logic         src_any;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_gate
      assign gated[g] = i_en[g] ? i_src[g*W +: W] : '0;
    end
  endgenerate

  assign mem_gated = i_mem_sel ? i_mem : '0;
  assign src_any   = |i_en;

  function automatic logic [W-1:0] or_reduce(input logic [W-1:0] v [N],
                                             input logic [W-1:0] extra);
    logic [W-1:0] acc;
    acc = extra;
    for (int k = 0; k < N; k++) acc = acc | v[k];
    return acc;
  endfunction

  always_comb o_bus = or_reduce(gated, mem_gated);

  always_comb begin
    if (!src_any && !i_mem_sel)
      AST_IDLE_BUS_ZERO: assert (o_bus == '0) else $error("idle bus not zero"); // R1
    if (!i_mem_sel)
      AST_BUS_FROM_SOURCES: assert ((o_bus & ~(i_src[0 +: W] | i_src[W +: W] | i_src[2*W +: W]
                                 | i_src[3*W +: W] | i_src[(N-1)*W +: W])) == '0)
        else $error("bus bit without source"); // R1
  end

endmodule

// File: rtl/opbus_addr_sum.sv
module opbus_addr_sum #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic [N*W-1:0] i_src,
  input  logic [N-1:0]   i_en,
  output logic [W-1:0]   o_sum,
  output logic           o_any
);

  logic [W-1:0] term [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_term
      assign term[g] = i_en[g] ? i_src[g*W +: W] : '0;
    end
  endgenerate

  // wrapping sum: carries beyond W bits are dropped
  function automatic logic [W-1:0] wrap_sum(input logic [W-1:0] v [N]);
    logic [W-1:0] acc;
    acc = '0;
    for (int k = 0; k < N; k++) acc = acc + v[k];
    return acc;
  endfunction

  assign o_sum = wrap_sum(term);
  assign o_any = |i_en;

  always_comb begin
    if (i_en == '0)
      AST_ADDR_IDLE_ZERO: assert (o_sum == '0) else $error("sum without sources"); // R3
    if ($onehot(i_en) && i_en[0])
      AST_ADDR_SINGLE: assert (o_sum == i_src[0 +: W]) else $error("single source sum"); // R3
  end

endmodule

// File: rtl/opbus_cycle_ctrl.sv
module opbus_cycle_ctrl
  import opbus_pkg::*;
(
  input  logic               i_addr_any,
  input  logic               i_data_any,
  input  logic [INSTR_W-1:0] i_instr,
  input  logic               i_bus_ctrl,
  input  logic               i_int_ack,
  output logic               o_vma,
  output logic               o_rnw,
  output logic               o_mem_sel,
  output logic               o_flag_out
);

  logic write_req;

  assign o_flag_out = is_flag_store(i_instr);
  assign o_vma      = i_bus_ctrl && !i_int_ack && i_addr_any;
  assign write_req  = (o_vma && i_data_any) || o_flag_out;
  assign o_rnw      = !write_req;
  assign o_mem_sel  = i_int_ack || (o_vma && o_rnw);

  always_comb begin
    if (i_int_ack)
      AST_VMA_IACK_LOW: assert (!o_vma) else $error("vma in vector read"); // R4
    if (!o_rnw)
      AST_WRITE_HAS_CAUSE: assert ((o_vma && i_data_any) || o_flag_out)
        else $error("write without cause"); // R5
    if (o_mem_sel && !i_int_ack)
      AST_MEM_ONLY_READ: assert (o_rnw && o_vma) else $error("memory merged on write"); // R2
  end

endmodule

// File: rtl/opbus_combiner.sv
module opbus_combiner
  import opbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int UPC_W  = 8
) (
  input  logic [DATA_W-1:0]  i_reg_p,
  input  logic [DATA_W-1:0]  i_reg_a,
  input  logic [DATA_W-1:0]  i_reg_x,
  input  logic [DATA_W-1:0]  i_reg_y,
  input  logic [DATA_W-1:0]  i_reg_s,
  input  logic [N_DSRC-1:0]  i_data_en,
  input  logic [N_ASRC-1:0]  i_addr_en,
  input  logic [DATA_W-1:0]  i_mem_din,
  input  logic [DATA_W-1:0]  i_flags,
  input  logic [INSTR_W-1:0] i_instr,
  input  logic [UPC_W-1:0]   i_upc,
  input  logic               i_bus_ctrl,
  input  logic               i_int_ack,
  input  logic               i_hold_ack,
  output logic [DATA_W-1:0]  o_int_bus,
  output logic [DATA_W-1:0]  o_addr,
  output logic               o_addr_oe,
  output logic               o_vma,
  output logic               o_rnw,
  output logic               o_pnd,
  output logic               o_ctl_oe,
  output logic [DATA_W-1:0]  o_dout,
  output logic               o_dout_oe
);

  localparam int UPC_PAD = DATA_W - UPC_W;

  logic [N_DSRC*DATA_W-1:0] dsrc;
  logic [N_ASRC*DATA_W-1:0] asrc;
  logic [DATA_W-1:0]        addr_sum;
  logic                     addr_any;
  logic                     mem_sel;
  logic                     flag_out;
  logic [DATA_W-1:0]        upc_ext;

  assign dsrc = {i_reg_s, i_reg_y, i_reg_x, i_reg_a, i_reg_p};
  assign asrc = {i_reg_s, i_reg_y, i_reg_x, i_reg_p};

  opbus_data_merge #(.W(DATA_W), .N(N_DSRC)) u_data (
    .i_src     (dsrc),
    .i_en      (i_data_en),
    .i_mem     (i_mem_din),
    .i_mem_sel (mem_sel),
    .o_bus     (o_int_bus)
  );

  opbus_addr_sum #(.W(DATA_W), .N(N_ASRC)) u_addr (
    .i_src (asrc),
    .i_en  (i_addr_en),
    .o_sum (addr_sum),
    .o_any (addr_any)
  );

  opbus_cycle_ctrl u_ctrl (
    .i_addr_any (addr_any),
    .i_data_any (|i_data_en),
    .i_instr    (i_instr),
    .i_bus_ctrl (i_bus_ctrl),
    .i_int_ack  (i_int_ack),
    .o_vma      (o_vma),
    .o_rnw      (o_rnw),
    .o_mem_sel  (mem_sel),
    .o_flag_out (flag_out)
  );

  assign upc_ext   = {{UPC_PAD{1'b0}}, i_upc};
  assign o_addr    = i_bus_ctrl ? addr_sum : upc_ext;
  assign o_pnd     = i_addr_en[ASRC_P];
  assign o_dout    = flag_out ? i_flags : o_int_bus;
  assign o_addr_oe = !i_hold_ack;
  assign o_ctl_oe  = !i_hold_ack;
  assign o_dout_oe = !i_hold_ack && !o_rnw;

  always_comb begin
    if (i_hold_ack)
      AST_HOLD_FLOAT: assert (!o_addr_oe && !o_ctl_oe && !o_dout_oe)
        else $error("driver active in hold"); // R9
    if (!i_bus_ctrl)
      AST_STEP_ON_ADDR: assert (!o_vma && o_addr[UPC_W-1:0] == i_upc)
        else $error("step index not on address bus"); // R8
    if (o_dout_oe)
      AST_DOUT_ON_WRITE: assert (!o_rnw) else $error("driving data on read"); // R9
  end

endmodule

// File: tb/opbus_combiner_bench.sv
`timescale 1ns/1ps
module opbus_combiner_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] rp, ra, rx, ry, rs, mem, flg, instr, ibus, addr, dout;
  logic [4:0]  de;
  logic [3:0]  ae;
  logic [7:0]  upc;
  logic        bc, ia, hold, addr_oe, vma, rnw, pnd, ctl_oe, dout_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  opbus_combiner u_opbus_combiner (
    .i_reg_p(rp), .i_reg_a(ra), .i_reg_x(rx), .i_reg_y(ry), .i_reg_s(rs),
    .i_data_en(de), .i_addr_en(ae), .i_mem_din(mem), .i_flags(flg),
    .i_instr(instr), .i_upc(upc), .i_bus_ctrl(bc), .i_int_ack(ia),
    .i_hold_ack(hold), .o_int_bus(ibus), .o_addr(addr), .o_addr_oe(addr_oe),
    .o_vma(vma), .o_rnw(rnw), .o_pnd(pnd), .o_ctl_oe(ctl_oe),
    .o_dout(dout), .o_dout_oe(dout_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mix(input int a, input int b);
    logic [31:0] h;
    h = (a * 32'h9E3779B1) ^ (b * 32'h85EBCA77);
    h = h ^ (h >> 13);
    if ((a % 7) == 0) return 16'hFFFF ^ h[3:0];
    return h[15:0] ^ h[31:16];
  endfunction

  logic [15:0] instr_set [4];
  initial begin
    instr_set[0] = 16'h0006; instr_set[1] = 16'h0003;
    instr_set[2] = 16'h0002; instr_set[3] = 16'h6003;
  end

  initial begin
    int idx;
    // all-quiet state
    rp = 0; ra = 0; rx = 0; ry = 0; rs = 0; mem = 16'hBEEF; flg = 0;
    de = 0; ae = 0; upc = 8'h5A; bc = 1; ia = 0; hold = 0; instr = 16'h0000;
    #1;
    check("R1 quiet bus", ibus, 16'h0000);
    check("R4 quiet vma", vma, 1'b0);
    check("R5 quiet rnw", rnw, 1'b1);
    check("R9 quiet oe", {addr_oe, ctl_oe, dout_oe}, 3'b110);
    idx = 0;
    for (int d = 0; d < 32; d++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 8; m++)
          for (int k = 0; k < 4; k++) begin
            logic [15:0] e_bus, e_sum, e_addr, e_dout;
            logic e_vma, e_rnw, e_sel, e_pat;
            idx++;
            rp = mix(idx, 1); ra = mix(idx, 2); rx = mix(idx, 3);
            ry = mix(idx, 4); rs = mix(idx, 5); mem = mix(idx, 6);
            flg = mix(idx, 7); upc = mix(idx, 8)[7:0];
            de = d[4:0]; ae = a[3:0];
            ia = m[0]; bc = m[1]; hold = m[2]; instr = instr_set[k];
            #1;
            e_pat = (instr == 16'h0006) || (instr == 16'h0003);
            e_vma = bc && !ia && (ae != 0);
            e_rnw = !((e_vma && de != 0) || e_pat);
            e_sel = ia || (e_vma && e_rnw);
            e_bus = (de[0] ? rp : 16'h0) | (de[1] ? ra : 16'h0) | (de[2] ? rx : 16'h0)
                  | (de[3] ? ry : 16'h0) | (de[4] ? rs : 16'h0) | (e_sel ? mem : 16'h0);
            e_sum = 16'((32'(ae[0] ? rp : 0) + 32'(ae[1] ? rx : 0)
                       + 32'(ae[2] ? ry : 0) + 32'(ae[3] ? rs : 0)) % 65536);
            e_addr = bc ? e_sum : {8'h00, upc};
            e_dout = e_pat ? flg : e_bus;
            check(e_sel ? "R2 bus with memory" : "R1 bus sources", ibus, e_bus);
            check(bc ? "R3 address sum" : "R8 step address", addr, e_addr);
            check(bc ? "R4 vma" : "R8 vma forced low", vma, e_vma);
            check("R5 rnw", rnw, e_rnw);
            check("R6 data out", dout, e_dout);
            check("R7 pnd", pnd, ae[0]);
            check("R9 enables", {addr_oe, ctl_oe, dout_oe},
                  {!hold, !hold, !hold && !e_rnw});
          end
    // wrap corner: all address sources at 0xFFFF
    rp = 16'hFFFF; rx = 16'hFFFF; ry = 16'hFFFF; rs = 16'hFFFF;
    ae = 4'hF; de = 0; bc = 1; ia = 0; hold = 0; instr = 16'h0000;
    #1;
    check("R3 wrap four ones", addr, 16'hFFFC);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule